// File: doc/BRIEF.md
# Switchable Domain Power Sequencer

This controller sits in the always-on part of a chip. It takes a switchable clock or power domain offline and brings it back. It drives three controls: a gate that lets register traffic cross into the domain, the domain's power enable, and the domain's active-high reset. It watches two inputs: an in-flight indication from the register crossing, and a power-good acknowledge from the power switch. Software asks for shutdown or startup through two request inputs. It reads back a two-bit status and a sticky drain-error flag.

The sequence always runs in a fixed order. Going down, it closes the gate, waits for the crossing to drain, removes power, and then asserts reset once power-good has gone low. Coming up, it restores power while reset is still held. It waits for power-good and holds reset for a programmable number of cycles. It then releases reset and finally reopens the gate. While the gate is closed, the crossing drops writes and replays the last read value, so the bus master is never stalled.

Every transition is registered, so no more than one of the three controls moves in any cycle. If the crossing stays busy too long, the shutdown is abandoned, the gate reopens and the error flag is set.

Top module: `dom_pwr_seq`

## Requirements
- R1: After reset, gate_open=1, pwr_en=1, dom_rst=0, seq_status=0 and drain_err=0.
- R2: A req_down sampled while idle-on clears gate_open at that edge, and leaves pwr_en and dom_rst unchanged.
- R3: pwr_en stays high while xing_busy is sampled high after the gate closed. pwr_en falls at the first edge that samples xing_busy low.
- R4: dom_rst rises only after pwr_en is low, at the first edge that samples pwr_good low. It then stays high until the reset hold has completed.
- R5: A req_up sampled while idle-off raises pwr_en. dom_rst stays high and gate_open stays low.
- R6: After pwr_good is sampled high during power-up, dom_rst stays high for RST_HOLD_CYC further cycles and then falls.
- R7: gate_open rises exactly one cycle after dom_rst falls. The block is then idle-on again.
- R8: If xing_busy is sampled high on DRAIN_LIMIT consecutive edges after the gate closed, gate_open reopens after exactly DRAIN_LIMIT cycles closed. In that case pwr_en never drops and drain_err is set. The next accepted req_down clears drain_err.
- R9: A request that does not match the idle state, or that arrives mid-sequence, is ignored.
- R10: seq_status is 0 when idle-on, 1 when idle-off and 2 while a sequence runs. The value 3 never appears.
- R11: At most one of gate_open, pwr_en and dom_rst changes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_down | input | 1 | Request to take the domain offline |
| req_up | input | 1 | Request to bring the domain back |
| xing_busy | input | 1 | Register crossing still has traffic in flight |
| pwr_good | input | 1 | Power switch acknowledge, high when the domain is powered |
| gate_open | output | 1 | Lets cross-domain register traffic through |
| pwr_en | output | 1 | Domain power enable |
| dom_rst | output | 1 | Domain reset, active high |
| seq_status | output | 2 | 0 idle-on, 1 idle-off, 2 sequencing |
| drain_err | output | 1 | Sticky flag for an abandoned shutdown |

## Verification
The bench targets three kinds of bug.

- Busy that clears on the very first drain cycle: a design that waits a fixed extra cycle would drop power late.
- Busy held for exactly the drain limit: an off-by-one counter would give up one cycle early or late, or would drop power anyway.
- Power-good arriving with random latency against the reset hold: a design that counts from power enable instead would release reset too early.

Requests fired during every phase catch a block that restarts or reverses mid-sequence. A check on every cycle that only one control moves catches merged transitions, such as power and reset changing together.

// File: rtl/dom_pwr_seq.sv
module dom_pwr_seq #(
  parameter int RST_HOLD_CYC = 4,
  parameter int DRAIN_LIMIT  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_down,
  input  logic       req_up,
  input  logic       xing_busy,
  input  logic       pwr_good,
  output logic       gate_open,
  output logic       pwr_en,
  output logic       dom_rst,
  output logic [1:0] seq_status,
  output logic       drain_err
);
  localparam int CMAX = (DRAIN_LIMIT > RST_HOLD_CYC) ? DRAIN_LIMIT : RST_HOLD_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DRAIN_LAST = CW'(DRAIN_LIMIT - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(RST_HOLD_CYC - 1);

  typedef enum logic [2:0] {
    S_ON, S_DRAIN, S_OFF_WAIT, S_OFF, S_PWR_WAIT, S_RST_HOLD, S_ALLOW_UP
  } st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          err_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    err_nx = drain_err;
    case (st)
      S_ON:
        if (req_down) begin
          st_nx  = S_DRAIN;
          cnt_nx = '0;
          err_nx = 1'b0;
        end
      S_DRAIN:
        if (!xing_busy) st_nx = S_OFF_WAIT;
        else if (cnt == DRAIN_LAST) begin
          st_nx  = S_ON;
          err_nx = 1'b1;
        end else cnt_nx = cnt + 1'b1;
      S_OFF_WAIT:
        if (!pwr_good) st_nx = S_OFF;
      S_OFF:
        if (req_up) st_nx = S_PWR_WAIT;
      S_PWR_WAIT:
        if (pwr_good) begin
          st_nx  = S_RST_HOLD;
          cnt_nx = '0;
        end
      S_RST_HOLD:
        if (cnt == HOLD_LAST) st_nx = S_ALLOW_UP;
        else cnt_nx = cnt + 1'b1;
      S_ALLOW_UP:
        st_nx = S_ON;
      default:
        st_nx = S_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_ON;
      cnt       <= '0;
      drain_err <= 1'b0;
    end else begin
      st        <= st_nx;
      cnt       <= cnt_nx;
      drain_err <= err_nx;
    end
  end

  assign gate_open  = (st == S_ON);
  assign pwr_en     = (st != S_OFF_WAIT) && (st != S_OFF);
  assign dom_rst    = (st == S_OFF) || (st == S_PWR_WAIT) || (st == S_RST_HOLD);
  assign seq_status = (st == S_ON) ? 2'd0 : (st == S_OFF) ? 2'd1 : 2'd2;
endmodule

module dom_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_down,
  input logic       xing_busy,
  input logic       pwr_good,
  input logic       gate_open,
  input logic       pwr_en,
  input logic       dom_rst,
  input logic [1:0] seq_status
);
  a_r2_gate_drop_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_open) |-> $past(req_down) && pwr_en && !dom_rst);
  a_r3_power_off_drained: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(!xing_busy) && !gate_open);
  a_r4_reset_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst) |-> !pwr_en && $past(!pwr_good));
  a_r5_power_up_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> dom_rst && !gate_open);
  a_r7_gate_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_open) |-> pwr_en && !dom_rst);
  a_r10_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    seq_status != 2'd3);
  a_r11_one_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gate_open, pwr_en, dom_rst} ^ $past({gate_open, pwr_en, dom_rst})) <= 1);
endmodule

bind dom_pwr_seq dom_pwr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_down(req_down), .xing_busy(xing_busy),
  .pwr_good(pwr_good), .gate_open(gate_open), .pwr_en(pwr_en),
  .dom_rst(dom_rst), .seq_status(seq_status)
);

// File: tb/dom_pwr_seq_tb_top.sv
module dom_pwr_seq_tb_top;
  localparam int HOLD = 5;
  localparam int LIM  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_down = 1'b0, req_up = 1'b0, xing_busy = 1'b0, pwr_good = 1'b1;
  logic gate_open, pwr_en, dom_rst, drain_err;
  logic [1:0] seq_status;

  int total = 0, bad = 0;
  int m_st = 0, m_cnt = 0, pg_wait = 0;
  logic m_err = 1'b0;
  logic [2:0] prev_ctl = 3'b110;
  bit done = 0;

  always #2 clk = ~clk;

  dom_pwr_seq #(.RST_HOLD_CYC(HOLD), .DRAIN_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_down(req_down), .req_up(req_up),
    .xing_busy(xing_busy), .pwr_good(pwr_good), .gate_open(gate_open),
    .pwr_en(pwr_en), .dom_rst(dom_rst), .seq_status(seq_status),
    .drain_err(drain_err)
  );

  function automatic logic e_gate(int s); return s == 0; endfunction
  function automatic logic e_pwr(int s);  return !(s == 2 || s == 3); endfunction
  function automatic logic e_rst(int s);  return s == 3 || s == 4 || s == 5; endfunction
  function automatic logic [1:0] e_stat(int s);
    return (s == 0) ? 2'd0 : (s == 3) ? 2'd1 : 2'd2;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R7 gate_open", gate_open, e_gate(m_st));
    chk("R3/R5 pwr_en", pwr_en, e_pwr(m_st));
    chk("R4/R6 dom_rst", dom_rst, e_rst(m_st));
    chk("R10 seq_status", seq_status, e_stat(m_st));
    chk("R8 drain_err", drain_err, m_err);
    chk("R11 single control change",
        ($countones({gate_open, pwr_en, dom_rst} ^ prev_ctl) <= 1), 1);
    prev_ctl = {gate_open, pwr_en, dom_rst};
  endtask

  task automatic model_step(input logic dn, input logic up, input logic bz, input logic pg);
    case (m_st)
      0: if (dn) begin m_st = 1; m_cnt = 0; m_err = 1'b0; end
      1: if (!bz) m_st = 2;
         else if (m_cnt == LIM - 1) begin m_st = 0; m_err = 1'b1; end
         else m_cnt++;
      2: if (!pg) m_st = 3;
      3: if (up) m_st = 4;
      4: if (pg) begin m_st = 5; m_cnt = 0; end
      5: if (m_cnt == HOLD - 1) m_st = 6; else m_cnt++;
      default: m_st = 0;
    endcase
  endtask

  task automatic cycle(input logic dn, input logic up, input logic bz);
    @(negedge clk);
    compare_all();
    if (pwr_good != pwr_en) begin
      if (pg_wait == 0) pwr_good = pwr_en;
      else pg_wait--;
    end else pg_wait = $urandom_range(0, 4);
    req_down  = dn;
    req_up    = up;
    xing_busy = bz;
    model_step(dn, up, bz, pwr_good);
  endtask

  task automatic go_idle_on();
    for (int i = 0; i < 200 && m_st != 0; i++) cycle(1'b0, m_st == 3, 1'b0);
  endtask

  task automatic go_idle_off();
    go_idle_on();
    cycle(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 200 && m_st != 3; i++) cycle(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lows;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset gate_open", gate_open, 1);
    chk("R1 reset pwr_en", pwr_en, 1);
    chk("R1 reset dom_rst", dom_rst, 0);
    chk("R1 reset seq_status", seq_status, 0);
    chk("R1 reset drain_err", drain_err, 0);

    // R3: busy low on the very first drain cycle
    cycle(1'b1, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R3 fast drain power off", pwr_en, 0);
    m_st = m_st; // model already advanced; outputs compared in next cycle
    go_idle_on();

    // R8: busy held exactly the limit
    cycle(1'b1, 1'b0, 1'b1);
    lows = 0;
    for (int i = 0; i < LIM + 10; i++) begin
      cycle(1'b0, 1'b0, 1'b1);
      if (!gate_open) lows++;
      else if (lows > 0) break;
    end
    chk("R8 gate closed cycles", lows, LIM);
    chk("R8 drain_err set", drain_err, 1);
    chk("R8 power kept on", pwr_en, 1);
    cycle(1'b1, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);
    chk("R8 drain_err cleared", drain_err, 0);

    // R8 boundary: busy clears on the last allowed cycle
    go_idle_on();
    cycle(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < LIM - 1; i++) cycle(1'b0, 1'b0, 1'b1);
    cycle(1'b0, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);
    chk("R3 late drain power off", pwr_en, 0);
    chk("R8 no error at boundary", drain_err, 0);

    // R9: wrong-state requests
    go_idle_off();
    cycle(1'b1, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);
    chk("R9 down while off ignored", seq_status, 1);
    chk("R9 power stays off", pwr_en, 0);
    go_idle_on();
    cycle(1'b0, 1'b1, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);
    chk("R9 up while on ignored", seq_status, 0);
    chk("R9 gate stays open", gate_open, 1);

    // random phase
    for (int i = 0; i < 6000; i++)
      cycle(($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
            ($urandom_range(0, 99) < ((i / 1500) * 30)));
    go_idle_on();
    @(negedge clk);
    compare_all();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule